// File: doc/BRIEF.md
# Self-ID Stream Merger

After a bus reset every node on a serial bus broadcasts a self-ID quadlet, and the link layer collects these into a receive buffer. The local node never receives its own quadlet, so the list it holds has a gap. This block reads that buffer as a stream of 32-bit words together with the byte count of the buffer. It produces the full list of self-ID quadlets in bus order, with the local node's own quadlet placed where it belongs.

A run begins with a one-cycle `start` pulse. That pulse carries the byte count, the local physical ID, the root flag and the locally built quadlet. The block pulls words through a valid/ready input only as it needs them. It steps over begin markers and stops at an end marker. Each candidate entry must be followed by its bitwise complement. The block hands out one entry per handshake on a valid/ready output. When the run ends it raises `done` for one cycle, together with the physical ID and root flag it latched at the start. Word pairs that fail the complement check are counted.

Top module: `sid_merge`

## Requirements
- R1: After reset `out_valid`, `in_ready` and `done` are low and `err_count` is zero.
- R2: An input word equal to 32'h0000_00E0 (begin marker) is consumed as 4 bytes and produces no output entry.
- R3: An input word equal to 32'h0000_0001 (end marker) ends the run. No further input word is accepted, and `done` follows.
- R4: A word followed directly by its bitwise complement is a valid entry. The pair consumes 8 bytes and only the first word is emitted. Entries leave in stream order.
- R5: When a valid entry satisfies (entry & 32'h3F80_0000) == (local_phy+1) << 24, the local quadlet is emitted just before that entry. That is, bits 29:24 equal local_phy+1 and bit 23 is zero.
- R6: When the byte count given at start is exactly 8, the local quadlet is emitted before any received entry.
- R7: When the root flag is set and the local physical ID is non-zero, the local quadlet is emitted after all received entries. A root with ID zero gets no appended quadlet.
- R8: A non-marker word whose successor is not its complement increments the error count. The block then drops only that word and re-examines the successor as a new first word.
- R9: `done` is a single-cycle pulse. It carries the physical ID and root flag latched at start, and no entry is offered while it is high.
- R10: While `out_valid` is high and `out_ready` low, `out_valid` stays high and `out_data` stays unchanged.
- R11: `err_count` is cleared by `start` and saturates at its maximum value.
- R12: The block never accepts more bytes than the byte count. When the count runs out the run ends. A lone non-marker word with no room for its complement counts as one error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; accepted only when idle |
| byte_count | input | CNT_W | Buffer length in bytes, latched at start |
| local_phy | input | PHY_W | Local physical ID, latched at start |
| local_root | input | 1 | Local node is root, latched at start |
| local_sid | input | 32 | Locally built self-ID quadlet, latched at start |
| in_valid | input | 1 | Input word available |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Block accepts the input word this cycle |
| out_valid | output | 1 | Output entry available |
| out_data | output | 32 | Output self-ID quadlet |
| out_ready | input | 1 | Sink accepts the output entry |
| done | output | 1 | One-cycle end-of-run pulse |
| done_phy | output | PHY_W | Physical ID reported with done |
| done_root | output | 1 | Root flag reported with done |
| err_count | output | ERR_W | Saturating count of failed complement checks |

## Verification
`in_ready` first rises in the cycle after the edge that samples `start`. An entry is offered in the cycle after the edge that accepts its complement word, or one handshake later when the local quadlet goes ahead of it. An appended tail quadlet is followed by `done` in the very next cycle. An entry that closes the run through the end marker reaches `done` four cycles after its handshake. The bench drives and samples only on falling edges. It predicts each handshake from the levels it sees there, and it collects entries into a queue instead of expecting them in fixed cycles. The result is compared only after `done` has been observed. The same cases are repeated with the sink stalling, to show that order and values do not depend on back-pressure.

// File: rtl/sid_merge_pkg.sv
package sid_merge_pkg;
  localparam int unsigned QUAD_W = 32;

  // Marker words that bracket the received self-ID list
  localparam logic [QUAD_W-1:0] MARK_BEGIN = 32'h0000_00E0;
  localparam logic [QUAD_W-1:0] MARK_END   = 32'h0000_0001;

  // Field compared against the successor physical ID (bit 23 included)
  localparam logic [QUAD_W-1:0] SUCC_MASK  = 32'h3F80_0000;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOCAL_HEAD,
    ST_FETCH_A,
    ST_CHECK_A,
    ST_FETCH_B,
    ST_LOCAL_INS,
    ST_EMIT,
    ST_TAIL,
    ST_LOCAL_TAIL,
    ST_DONE
  } merge_state_t;
endpackage

// File: rtl/sid_word_class.sv
module sid_word_class
  import sid_merge_pkg::*;
#(
  parameter int unsigned PHY_W = 6
) (
  input  logic [QUAD_W-1:0] word_a,
  input  logic [QUAD_W-1:0] word_b,
  input  logic [PHY_W-1:0]  phy_id,
  output logic              is_begin,
  output logic              is_end,
  output logic              is_pair,
  output logic              is_successor
);
  logic [PHY_W:0]    next_id;
  logic [QUAD_W-1:0] want;

  always_comb begin
    next_id      = {1'b0, phy_id} + {{PHY_W{1'b0}}, 1'b1};
    want         = QUAD_W'(next_id) << 24;
    is_begin     = (word_a == MARK_BEGIN);
    is_end       = (word_a == MARK_END);
    is_pair      = (word_b == ~word_a);
    is_successor = ((word_a & SUCC_MASK) == want);
  end
endmodule

// File: rtl/sid_byte_budget.sv
module sid_byte_budget #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             take,
  output logic             has_word
);
  localparam logic [CNT_W-1:0] QBYTES = CNT_W'(4);

  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)       left <= '0;
    else if (load) left <= load_val;
    else if (take) left <= left - QBYTES;
  end

  assign has_word = (left >= QBYTES);

  // R12: a word is never taken once the byte budget is spent
  p_no_overdraw_r12: assert property (@(posedge clk) disable iff (rst)
    take |-> has_word);
endmodule

// File: rtl/sid_err_counter.sv
module sid_err_counter #(
  parameter int unsigned ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [ERR_W-1:0] count
);
  localparam logic [ERR_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)              count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end

  // R11: without a clear the count never decreases
  p_monotone_r11: assert property (@(posedge clk) disable iff (rst)
    !clr |=> count >= $past(count));

  // R11: a full counter stays full until cleared
  p_saturate_r11: assert property (@(posedge clk) disable iff (rst)
    (count == TOP && !clr) |=> count == TOP);
endmodule

// File: rtl/sid_merge.sv
module sid_merge
  import sid_merge_pkg::*;
#(
  parameter int unsigned PHY_W = 6,
  parameter int unsigned CNT_W = 12,
  parameter int unsigned ERR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [PHY_W-1:0]  local_phy,
  input  logic              local_root,
  input  logic [QUAD_W-1:0] local_sid,
  input  logic              in_valid,
  input  logic [QUAD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [QUAD_W-1:0] out_data,
  input  logic              out_ready,
  output logic              done,
  output logic [PHY_W-1:0]  done_phy,
  output logic              done_root,
  output logic [ERR_W-1:0]  err_count
);
  localparam logic [CNT_W-1:0] MARKERS_ONLY = CNT_W'(8);

  merge_state_t      st;
  logic [PHY_W-1:0]  phy_q;
  logic              root_q;
  logic [QUAD_W-1:0] lsid_q;
  logic [QUAD_W-1:0] word_a;

  logic is_begin, is_end, is_pair, is_successor;
  logic has_word, take, load, err_inc;

  sid_word_class #(.PHY_W(PHY_W)) u_class (
    .word_a       (word_a),
    .word_b       (in_data),
    .phy_id       (phy_q),
    .is_begin     (is_begin),
    .is_end       (is_end),
    .is_pair      (is_pair),
    .is_successor (is_successor)
  );

  sid_byte_budget #(.CNT_W(CNT_W)) u_budget (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (byte_count),
    .take     (take),
    .has_word (has_word)
  );

  sid_err_counter #(.ERR_W(ERR_W)) u_err (
    .clk   (clk),
    .rst   (rst),
    .clr   (load),
    .inc   (err_inc),
    .count (err_count)
  );

  assign load     = (st == ST_IDLE) && start;
  assign in_ready = ((st == ST_FETCH_A) && has_word) || (st == ST_FETCH_B);
  assign take     = in_valid && in_ready;
  assign err_inc  = ((st == ST_CHECK_A) && !is_begin && !is_end && !has_word) ||
                    ((st == ST_FETCH_B) && in_valid && !is_pair);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      phy_q  <= '0;
      root_q <= 1'b0;
      lsid_q <= '0;
      word_a <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          phy_q  <= local_phy;
          root_q <= local_root;
          lsid_q <= local_sid;
          st     <= (byte_count == MARKERS_ONLY) ? ST_LOCAL_HEAD : ST_FETCH_A;
        end
        ST_LOCAL_HEAD: if (out_ready) st <= ST_FETCH_A;
        ST_FETCH_A: begin
          if (!has_word) st <= ST_TAIL;
          else if (in_valid) begin
            word_a <= in_data;
            st     <= ST_CHECK_A;
          end
        end
        ST_CHECK_A: begin
          if (is_begin)      st <= ST_FETCH_A;
          else if (is_end)   st <= ST_TAIL;
          else if (!has_word) st <= ST_TAIL;
          else               st <= ST_FETCH_B;
        end
        ST_FETCH_B: if (in_valid) begin
          if (is_pair) st <= is_successor ? ST_LOCAL_INS : ST_EMIT;
          else begin
            word_a <= in_data;
            st     <= ST_CHECK_A;
          end
        end
        ST_LOCAL_INS:  if (out_ready) st <= ST_EMIT;
        ST_EMIT:       if (out_ready) st <= ST_FETCH_A;
        ST_TAIL:       st <= (root_q && phy_q != '0) ? ST_LOCAL_TAIL : ST_DONE;
        ST_LOCAL_TAIL: if (out_ready) st <= ST_DONE;
        ST_DONE:       st <= ST_IDLE;
        default:       st <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = (st == ST_LOCAL_HEAD) || (st == ST_LOCAL_INS) ||
                     (st == ST_EMIT) || (st == ST_LOCAL_TAIL);
  assign out_data  = (st == ST_EMIT) ? word_a : lsid_q;
  assign done      = (st == ST_DONE);
  assign done_phy  = phy_q;
  assign done_root = root_q;

  // R10: an offered entry is held until taken
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9: done lasts exactly one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: nothing is offered while done is high
  p_quiet_done_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid);

  // R3: no input is accepted while the run is closing
  p_no_take_done_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);

  // R7: taking the appended local quadlet ends the run on the next cycle
  p_tail_then_done_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOCAL_TAIL && out_ready) |=> done);
endmodule

// File: tb/sid_merge_tb.sv
`timescale 1ns/100ps
module sid_merge_tb;
  localparam int PHY_W = 6;
  localparam int CNT_W = 12;
  localparam int ERR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  byte_count = '0;
  logic [PHY_W-1:0]  local_phy = '0;
  logic              local_root = 1'b0;
  logic [31:0]       local_sid = '0;
  logic              in_valid = 1'b0;
  logic [31:0]       in_data = '0;
  logic              in_ready;
  logic              out_valid;
  logic [31:0]       out_data;
  logic              out_ready = 1'b1;
  logic              done;
  logic [PHY_W-1:0]  done_phy;
  logic              done_root;
  logic [ERR_W-1:0]  err_count;

  always #2.5 clk = ~clk;

  sid_merge #(.PHY_W(PHY_W), .CNT_W(CNT_W), .ERR_W(ERR_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .byte_count(byte_count),
    .local_phy(local_phy), .local_root(local_root), .local_sid(local_sid),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .done(done), .done_phy(done_phy), .done_root(done_root),
    .err_count(err_count)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] src[$];
  logic [31:0] got[$];
  int  idx = 0;
  bit  take_pend = 1'b0;
  bit  stall_en = 1'b0;
  int  cyc = 0;
  int  done_cnt = 0;
  logic [PHY_W-1:0] seen_phy;
  logic seen_root;
  bit  hold_prev = 1'b0;
  logic [31:0] hold_data;
  int  hold_bad = 0;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sid(input int k);
    return 32'h8004_1200 | (32'(k) << 24) | 32'(k);
  endfunction

  function automatic logic [31:0] lsid(input int p);
    return 32'h8040_0C00 | (32'(p) << 24);
  endfunction

  // Falling-edge driver and monitor: every value seen here is stable
  initial forever begin
    @(negedge clk);
    if (take_pend) idx++;
    in_valid = (idx < src.size());
    in_data  = in_valid ? src[idx] : 32'h0;
    out_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
    if (hold_prev && (!out_valid || out_data != hold_data)) hold_bad++;
    hold_prev = out_valid && !out_ready;
    hold_data = out_data;
    if (out_valid && out_ready) got.push_back(out_data);
    take_pend = in_valid && in_ready;
    if (done) begin
      done_cnt++;
      seen_phy  = done_phy;
      seen_root = done_root;
    end
    cyc++;
  end

  task automatic run_case(input string req, input int cnt, input int phy,
                          input bit root, input logic [31:0] words[$],
                          input logic [31:0] exp[$], input int exp_err,
                          input int exp_taken);
    int waited;
    @(posedge clk); #1;
    src = words;
    idx = 0;
    got.delete();
    done_cnt = 0;
    hold_bad = 0;
    byte_count = CNT_W'(cnt);
    local_phy  = PHY_W'(phy);
    local_root = root;
    local_sid  = lsid(phy);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    waited = 0;
    while (done_cnt == 0 && waited < 5000) begin
      @(posedge clk); #1;
      waited++;
    end
    repeat (3) @(posedge clk);
    #1;
    check({req, " R9"}, "done pulses once", done_cnt, 1);
    check({req, " R9"}, "done phy", seen_phy, phy);
    check({req, " R9"}, "done root", seen_root, root);
    check(req, "entry count", got.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got.size(); i++)
      check(req, $sformatf("entry %0d", i), got[i], exp[i]);
    check({req, " R8"}, "error count", err_count, exp_err);
    check({req, " R12"}, "words taken", idx, exp_taken);
    check({req, " R10"}, "hold violations", hold_bad, 0);
  endtask

  task automatic t_reset();
    check("R1", "out_valid", out_valid, 0);
    check("R1", "in_ready", in_ready, 0);
    check("R1", "done", done, 0);
    check("R1", "err_count", err_count, 0);
  endtask

  task automatic t_insert(input bit stall);
    logic [31:0] w[$];
    logic [31:0] e[$];
    stall_en = stall;
    w = '{32'hE0, sid(0), ~sid(0), sid(1), ~sid(1), sid(3), ~sid(3), 32'h1};
    e = '{sid(0), sid(1), lsid(2), sid(3)};
    run_case(stall ? "R10 R5 R4 R2" : "R2 R4 R5", 32, 2, 1'b0, w, e, 0, 8);
    stall_en = 1'b0;
  endtask

  task automatic t_root_tail();
    logic [31:0] w[$];
    logic [31:0] e[$];
    w = '{32'hE0, sid(0), ~sid(0), sid(1), ~sid(1), sid(2), ~sid(2), 32'h1};
    e = '{sid(0), sid(1), sid(2), lsid(3)};
    run_case("R7", 32, 3, 1'b1, w, e, 0, 8);
  endtask

  task automatic t_lonely();
    logic [31:0] w[$];
    logic [31:0] e[$];
    w = '{32'hE0, 32'h1};
    e = '{lsid(0)};
    run_case("R6 R7 root id0", 8, 0, 1'b1, w, e, 0, 2);
    e = '{lsid(5)};
    run_case("R6", 8, 5, 1'b0, w, e, 0, 2);
  endtask

  task automatic t_bad_pair();
    logic [31:0] w[$];
    logic [31:0] e[$];
    w = '{32'hE0, sid(0), 32'h1234_5678, sid(1), ~sid(1), 32'h1};
    e = '{sid(1)};
    run_case("R8", 24, 7, 1'b0, w, e, 2, 6);
  endtask

  task automatic t_end_stop();
    logic [31:0] w[$];
    logic [31:0] e[$];
    w = '{32'hE0, sid(0), ~sid(0), 32'h1, sid(4), ~sid(4)};
    e = '{sid(0)};
    run_case("R3", 24, 9, 1'b0, w, e, 0, 4);
  endtask

  task automatic t_bit23();
    logic [31:0] w[$];
    logic [31:0] e[$];
    logic [31:0] s;
    s = sid(2) | 32'h0080_0000;
    w = '{32'hE0, s, ~s, 32'h1};
    e = '{s};
    run_case("R5 bit23", 16, 1, 1'b0, w, e, 0, 4);
  endtask

  task automatic t_budget();
    logic [31:0] w[$];
    logic [31:0] e[$];
    w = '{32'hE0, sid(0), ~sid(0)};
    e = '{sid(0)};
    run_case("R12 no end", 12, 4, 1'b0, w, e, 0, 3);
    w = '{32'hE0, 32'hE0, sid(0), ~sid(0)};
    e.delete();
    run_case("R12 lone", 12, 4, 1'b0, w, e, 1, 3);
  endtask

  task automatic t_saturate();
    logic [31:0] w[$];
    logic [31:0] e[$];
    for (int i = 0; i < 300; i++) w.push_back(32'h5);
    e.delete();
    run_case("R11 saturate", 1200, 4, 1'b0, w, e, 255, 300);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_insert(1'b0);
    t_root_tail();
    t_lonely();
    t_bad_pair();
    t_end_stop();
    t_bit23();
    t_budget();
    t_saturate();
    t_insert(1'b0);   // R11: count cleared at the next start
    t_insert(1'b1);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule